// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is a free-running time-of-day and calendar counter. A 15-bit divider counts a 32.768 kHz enable pulse and produces a one-second step. Each step advances seconds, minutes and hours in 24-hour form, along with a day-of-week counter, day of month, month, two-digit year and a two-digit century. Every field is held in packed BCD: the tens digit sits in the upper nibble and the units digit in the lower nibble. Month lengths are applied automatically. February gains a 29th day whenever the year value is a multiple of four, including year 00.

A host sets the time with a single-cycle load strobe. The strobe writes every field at once and restarts the sub-second divider, so the next second arrives exactly one full divider period later. Bit 7 of the loaded seconds byte stops the oscillator, which freezes the divider and every field. Bit 6 of the loaded day byte selects a frequency-test mode. In that mode, while the oscillator runs, the seconds LSB output carries a 512 Hz square wave taken from the divider instead of the true seconds units bit. The outputs are the live register values.

Top module: `bcd_calendar_top`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00, century 20, with the stop bit (seconds bit 7) and the test bit (day bit 6) both 0.
- R2: A one-cycle `load_strobe` makes all loaded fields visible on the outputs after the next clock edge and restarts the divider. The seconds field then advances on exactly the 2^DIV_W-th following clock edge with `tick_32k` high.
- R3: Seconds wrap 59 to 00 and carry into minutes, minutes wrap 59 to 00 and carry into hours, and hours wrap 23 to 00. All of these are BCD, with units in bits 3:0 and tens above.
- R4: At each midnight the day-of-week field advances by one and wraps from 07 to 01, independently of the date.
- R5: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 in month 02 of a non-leap year. Month 12 wraps to 01 and carries into the year.
- R6: A year whose value is divisible by four, including 00, is a leap year, and February then reaches 29 before rolling to March 01.
- R7: Year 99 wraps to 00 and increments the century, and century 39 wraps to 00.
- R8: While seconds bit 7 is 1, no field changes whatever `tick_32k` does, and bit 7 reads back as 1. Loading a 0 into that bit restarts counting.
- R9: When day bit 6 is 1 and the oscillator runs, seconds bit 0 reads the divider bit TOGGLE_BIT (a 512 Hz square wave at default size). Otherwise it reads the true seconds units LSB. Day bit 6 reads back the test setting.
- R10: Without a `tick_32k` pulse no output changes. Idle cycles between ticks neither lose nor add time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| load_strobe | input | 1 | One-cycle load of all fields |
| load_sec | input | 8 | Seconds BCD; bit 7 is the oscillator stop |
| load_min | input | 8 | Minutes BCD |
| load_hour | input | 8 | Hours BCD, 00-23 |
| load_day | input | 8 | Day of week 1-7 in bits 2:0; bit 6 is frequency test |
| load_date | input | 8 | Day of month BCD |
| load_month | input | 8 | Month BCD |
| load_year | input | 8 | Year BCD |
| load_century | input | 8 | Century BCD, 00-39 |
| sec_o | output | 8 | Stop bit, seconds BCD, LSB possibly test toggle |
| min_o | output | 8 | Minutes BCD |
| hour_o | output | 8 | Hours BCD |
| day_o | output | 8 | Test bit in bit 6, day of week in bits 2:0 |
| date_o | output | 8 | Day of month BCD |
| month_o | output | 8 | Month BCD |
| year_o | output | 8 | Year BCD |
| century_o | output | 8 | Century BCD |

## Verification
A load is visible at the first sampling point after its clock edge. From then on, the seconds value changes one edge after the divider has seen its full count of ticks. With the bench's 4-bit divider and `tick_32k` held high, that is the 16th edge after the load edge. The bench drives on the falling edge and samples on the next falling edge. Its model counts every tick it drove and applies a second exactly at the sample following the 16th tick, so idle cycles and random tick gaps are accounted for. The test-mode LSB is predicted from the number of ticks since the last load, at the same sampling points.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       ftest;
        logic [2:0] day;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
        logic [5:0] century;
    } cal_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // last valid date of a month, returned in BCD
    function automatic logic [5:0] month_last(input logic [4:0] month,
                                              input logic [7:0] year);
        logic [6:0] mb;
        logic [6:0] yb;
        mb = bcd_to_bin({3'd0, month});
        yb = bcd_to_bin(year);
        case (mb)
            7'd2:                      return (yb[1:0] == 2'd0) ? 6'h29 : 6'h28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 6'h30;
            default:                   return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
    parameter int DIV_W      = 15,
    parameter int TOGGLE_BIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clear,
    output logic sec_pulse,
    output logic toggle
);
    localparam logic [DIV_W-1:0] CNT_LAST = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        sec_pulse = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && run) begin
            cnt_d     = cnt_q + 1'b1;
            sec_pulse = (cnt_q == CNT_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign toggle = cnt_q[TOGGLE_BIT];
endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic [5:0] last_date;

    always_comb begin
        last_date = month_last(cur.month, cur.year);
        nxt = cur;
        if (cur.sec == 7'h59) begin
            nxt.sec = '0;
            if (cur.min == 7'h59) begin
                nxt.min = '0;
                if (cur.hour == 6'h23) begin
                    nxt.hour = '0;
                    nxt.day  = (cur.day == 3'd7) ? 3'd1 : cur.day + 3'd1;
                    if (cur.date == last_date) begin
                        nxt.date = 6'h01;
                        if (cur.month == 5'h12) begin
                            nxt.month = 5'h01;
                            if (cur.year == 8'h99) begin
                                nxt.year    = 8'h00;
                                nxt.century = (cur.century == 6'h39) ? 6'h00
                                              : 6'(bcd_inc({2'b0, cur.century}));
                            end else begin
                                nxt.year = bcd_inc(cur.year);
                            end
                        end else begin
                            nxt.month = 5'(bcd_inc({3'b0, cur.month}));
                        end
                    end else begin
                        nxt.date = 6'(bcd_inc({2'b0, cur.date}));
                    end
                end else begin
                    nxt.hour = 6'(bcd_inc({2'b0, cur.hour}));
                end
            end else begin
                nxt.min = 7'(bcd_inc({1'b0, cur.min}));
            end
        end else begin
            nxt.sec = 7'(bcd_inc({1'b0, cur.sec}));
        end
    end
endmodule

// File: rtl/bcd_calendar_top.sv
module bcd_calendar_top
    import cal_pkg::*;
#(
    parameter int DIV_W      = 15,
    parameter int TOGGLE_BIT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       load_strobe,
    input  logic [7:0] load_sec,
    input  logic [7:0] load_min,
    input  logic [7:0] load_hour,
    input  logic [7:0] load_day,
    input  logic [7:0] load_date,
    input  logic [7:0] load_month,
    input  logic [7:0] load_year,
    input  logic [7:0] load_century,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] day_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] century_o
);
    localparam cal_t RESET_VAL = '{stop: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00,
                                   ftest: 1'b0, day: 3'd1, date: 6'h01, month: 5'h01,
                                   year: 8'h00, century: 6'h20};

    cal_t st_d, st_q, st_adv;
    logic sec_pulse, toggle;

    cal_divider #(.DIV_W(DIV_W), .TOGGLE_BIT(TOGGLE_BIT)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .run      (!st_q.stop),
        .clear    (load_strobe),
        .sec_pulse(sec_pulse),
        .toggle   (toggle)
    );

    cal_advance u_adv (
        .cur(st_q),
        .nxt(st_adv)
    );

    always_comb begin
        st_d = st_q;
        if (load_strobe) begin
            st_d.stop    = load_sec[7];
            st_d.sec     = load_sec[6:0];
            st_d.min     = load_min[6:0];
            st_d.hour    = load_hour[5:0];
            st_d.ftest   = load_day[6];
            st_d.day     = load_day[2:0];
            st_d.date    = load_date[5:0];
            st_d.month   = load_month[4:0];
            st_d.year    = load_year;
            st_d.century = load_century[5:0];
        end else if (sec_pulse) begin
            st_d = st_adv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_VAL;
        else        st_q <= st_d;
    end

    logic sec_lsb;
    assign sec_lsb   = (st_q.ftest && !st_q.stop) ? toggle : st_q.sec[0];
    assign sec_o     = {st_q.stop, st_q.sec[6:1], sec_lsb};
    assign min_o     = {1'b0, st_q.min};
    assign hour_o    = {2'b0, st_q.hour};
    assign day_o     = {1'b0, st_q.ftest, 3'b0, st_q.day};
    assign date_o    = {2'b0, st_q.date};
    assign month_o   = {3'b0, st_q.month};
    assign year_o    = st_q.year;
    assign century_o = {2'b0, st_q.century};
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic       load_strobe,
    input logic [7:0] load_sec,
    input logic [7:0] load_min,
    input logic [7:0] load_hour,
    input logic [7:0] load_date,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] day_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic [7:0] century_o
);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> (sec_o[7:1] == $past(load_sec[7:1])) && (min_o == {1'b0, $past(load_min[6:0])})
                        && (hour_o == {2'b0, $past(load_hour[5:0])}) && (date_o == {2'b0, $past(load_date[5:0])}));

    p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[3:0] <= 4'd9) && (sec_o[6:4] <= 3'd5));

    p_day_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (day_o[2:0] != 3'd0));

    p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[7] && !load_strobe) |=> $stable({sec_o, min_o, hour_o, day_o, date_o, month_o, year_o, century_o}));

    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_32k && !load_strobe) |=> $stable({sec_o, min_o, hour_o, day_o, date_o, month_o, year_o, century_o}));
endmodule

bind bcd_calendar_top cal_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .load_strobe(load_strobe),
    .load_sec(load_sec), .load_min(load_min), .load_hour(load_hour), .load_date(load_date),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .century_o(century_o)
);

// File: tb/sim_bcd_calendar_top.sv
`timescale 1ns/1ps
module sim_bcd_calendar_top;
    localparam int DW = 4;
    localparam int TB = 1;
    localparam int PER = 1 << DW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, tick_32k = 1'b0, load_strobe = 1'b0;
    logic [7:0] load_sec = 0, load_min = 0, load_hour = 0, load_day = 0;
    logic [7:0] load_date = 0, load_month = 0, load_year = 0, load_century = 0;
    logic [7:0] sec_o, min_o, hour_o, day_o, date_o, month_o, year_o, century_o;

    bcd_calendar_top #(.DIV_W(DW), .TOGGLE_BIT(TB)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    int m_sec = 0, m_min = 0, m_hr = 0, m_day = 1, m_date = 1, m_mon = 1, m_yr = 0, m_cen = 20;
    int m_stop = 0, m_ft = 0;

    function automatic logic [7:0] tobcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mo, int yr);
        case (mo)
            2: return (yr % 4 == 0) ? 29 : 28;
            4, 6, 9, 11: return 30;
            default: return 31;
        endcase
    endfunction

    task automatic step_model();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin
            m_hr = 0;
            m_day = (m_day == 7) ? 1 : m_day + 1;
            m_date++;
            if (m_date > dim(m_mon, m_yr)) begin m_date = 1; m_mon++; end
            if (m_mon == 13) begin m_mon = 1; m_yr++; end
            if (m_yr == 100) begin m_yr = 0; m_cen++; end
            if (m_cen == 40) m_cen = 0;
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cnt: ticks since the last divider restart (mod PER)
    task automatic check_all(string req, int cnt);
        logic [7:0] es;
        es = {m_stop[0], tobcd(m_sec)[6:0]};
        if (m_ft != 0 && m_stop == 0) es[0] = cnt[TB];
        chk(sec_o == es, req, "sec", sec_o, es);
        chk(min_o == tobcd(m_min), req, "min", min_o, tobcd(m_min));
        chk(hour_o == tobcd(m_hr), req, "hour", hour_o, tobcd(m_hr));
        chk(day_o == (8'(m_day) | (m_ft != 0 ? 8'h40 : 8'h00)), req, "day", day_o,
            8'(m_day) | (m_ft != 0 ? 8'h40 : 8'h00));
        chk(date_o == tobcd(m_date), req, "date", date_o, tobcd(m_date));
        chk(month_o == tobcd(m_mon), req, "month", month_o, tobcd(m_mon));
        chk(year_o == tobcd(m_yr), req, "year", year_o, tobcd(m_yr));
        chk(century_o == tobcd(m_cen), req, "century", century_o, tobcd(m_cen));
    endtask

    task automatic do_load(int cen, int yr, int mo, int dt, int dy, int hr, int mi, int se,
                           int stp, int ft);
        @(negedge clk);
        load_sec = {stp[0], tobcd(se)[6:0]};
        load_min = tobcd(mi); load_hour = tobcd(hr);
        load_day = {1'b0, ft[0], 3'b0, dy[2:0]};
        load_date = tobcd(dt); load_month = tobcd(mo);
        load_year = tobcd(yr); load_century = tobcd(cen);
        load_strobe = 1'b1;
        @(negedge clk);
        load_strobe = 1'b0;
        m_cen = cen; m_yr = yr; m_mon = mo; m_date = dt; m_day = dy;
        m_hr = hr; m_min = mi; m_sec = se; m_stop = stp; m_ft = ft;
        check_all("R2", 0);
    endtask

    task automatic run_secs(int n, string req);
        for (int i = 0; i < n; i++) begin
            repeat (PER) @(negedge clk);
            step_model();
            check_all(req, 0);
        end
    endtask

    task automatic rand_phase(int cycles);
        int cnt = 0;
        bit adv;
        for (int i = 0; i < cycles; i++) begin
            bit t;
            t = ($urandom % 3) != 0;
            tick_32k = t;
            adv = t && (cnt == PER - 1) && (m_stop == 0);
            if (t && m_stop == 0) cnt = (cnt + 1) % PER;
            @(negedge clk);
            if (adv) step_model();
            check_all("R10", cnt);
        end
        tick_32k = 1'b1;
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        check_all("R1", 0);
        rst_n = 1'b1;
        tick_32k = 1'b1;

        // R2: exact second timing after a load
        do_load(20, 23, 12, 31, 3, 10, 15, 20, 0, 0);
        repeat (PER - 1) @(negedge clk);
        chk(sec_o == 8'h20, "R2", "sec before period end", sec_o, 8'h20);
        @(negedge clk);
        chk(sec_o == 8'h21, "R2", "sec at period end", sec_o, 8'h21);
        m_sec = 21;

        // R3: time carries
        do_load(20, 23, 5, 10, 2, 11, 59, 58, 0, 0);
        run_secs(3, "R3");
        // R4: midnight and weekday wrap
        do_load(20, 23, 5, 10, 7, 23, 59, 59, 0, 0);
        run_secs(2, "R4");
        chk(day_o == 8'h01, "R4", "weekday wrap", day_o, 8'h01);
        // R5: month lengths
        do_load(20, 23, 4, 30, 1, 23, 59, 59, 0, 0);  run_secs(1, "R5");
        do_load(20, 23, 1, 31, 1, 23, 59, 59, 0, 0);  run_secs(1, "R5");
        do_load(20, 23, 2, 28, 1, 23, 59, 59, 0, 0);  run_secs(1, "R5");
        chk(month_o == 8'h03, "R5", "feb non-leap", month_o, 8'h03);
        do_load(20, 23, 11, 30, 1, 23, 59, 59, 0, 0); run_secs(1, "R5");
        do_load(20, 23, 12, 31, 1, 23, 59, 59, 0, 0); run_secs(1, "R5");
        // R6: leap years
        do_load(20, 24, 2, 28, 1, 23, 59, 59, 0, 0);  run_secs(1, "R6");
        chk(date_o == 8'h29, "R6", "feb 29 yr24", date_o, 8'h29);
        do_load(20, 24, 2, 29, 1, 23, 59, 59, 0, 0);  run_secs(1, "R6");
        do_load(20, 0, 2, 28, 1, 23, 59, 59, 0, 0);   run_secs(1, "R6");
        chk(date_o == 8'h29, "R6", "feb 29 yr00", date_o, 8'h29);
        // R7: year and century wrap
        do_load(19, 99, 12, 31, 4, 23, 59, 59, 0, 0); run_secs(1, "R7");
        chk(century_o == 8'h20, "R7", "century carry", century_o, 8'h20);
        do_load(39, 99, 12, 31, 4, 23, 59, 59, 0, 0); run_secs(1, "R7");
        chk(century_o == 8'h00, "R7", "century wrap", century_o, 8'h00);
        // R8: stop bit freezes, even with test mode set
        do_load(20, 23, 6, 15, 5, 10, 20, 31, 1, 1);
        repeat (5 * PER) @(negedge clk);
        check_all("R8", 0);
        do_load(20, 23, 6, 15, 5, 10, 20, 31, 0, 0);
        run_secs(2, "R8");
        // R9: test toggle replaces the seconds LSB
        do_load(20, 23, 6, 15, 5, 10, 20, 30, 0, 1);
        for (int j = 1; j < PER; j++) begin
            @(negedge clk);
            check_all("R9", j);
        end
        @(negedge clk);
        step_model();
        check_all("R9", 0);
        chk(sec_o[0] == 1'b0, "R9", "toggle replaces lsb of 31", sec_o[0], 0);

        // R10 and random mix
        for (int k = 0; k < 40; k++) begin
            int yr, mo, dt;
            yr = $urandom % 100;
            mo = 1 + $urandom % 12;
            dt = ($urandom % 2 != 0) ? dim(mo, yr) : 1 + $urandom % dim(mo, yr);
            do_load($urandom % 40, yr, mo, dt, 1 + $urandom % 7,
                    ($urandom % 2 != 0) ? 23 : $urandom % 24, 59, 50 + $urandom % 10,
                    0, $urandom % 2);
            rand_phase(400);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule